// File: doc/BRIEF.md
# MSB-First Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes. The line idles high. A falling edge starts a frame. The low level is confirmed at the middle of the start bit, and each later bit is sampled at its own middle. Sampling is paced by an oversampling tick input that pulses a fixed number of times per bit. The block does not generate this tick itself.

Eight data bits arrive most significant bit first. An optional parity bit may follow them, and a stop bit closes the frame. At the stop bit the assembled byte is copied into a one-byte receive buffer.

Status is reported through sticky flags that software clears by writing 1: buffer full, overrun, parity error and framing error. A busy flag shows when a frame is in progress. The interrupt line is raised by the full flag or the overrun flag.

Top module: `msb_uart_rx`

## Requirements
- R1: While the line stays high, the receiver stays idle: busy is 0 and no flag changes. A low level seen by the receiver starts start-bit qualification.
- R2: A low pulse that has ended before the midpoint of the start bit (tick TICKS_PER_BIT/2) is rejected. The receiver returns to idle without loading a byte or setting any flag.
- R3: Eight data bits are assembled most significant bit first. The first data bit after the start bit ends up in rxData[7].
- R4: rxData changes only when a frame completes. Between frames it holds its value.
- R5: When parityEn=1, one parity bit follows the eighth data bit. With parityOdd=0 (even parity) the parity bit equals the XOR of the data bits. With parityOdd=1 (odd parity) it equals the inverse of that XOR. A mismatch at load sets parityErr. When parityEn=0, no parity bit is expected and parityErr never sets.
- R6: full sets when a byte is loaded. It stays set until a cycle with clrFull=1, which clears it.
- R7: If a byte is loaded while full is already 1, overrun sets and the new byte replaces the buffer contents. overrun clears only through clrOverrun.
- R8: busy is 1 from start detection until the byte is loaded. It is 0 once full rises.
- R9: A low stop bit sets frameErr, which clears only through clrFrame. The byte is still loaded.
- R10: irq is 1 exactly when full or overrun is 1.
- R11: After reset, rxData is 0 and busy, full, overrun, parityErr, frameErr and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Oversampling tick, TICKS_PER_BIT pulses per bit |
| serialIn | input | 1 | Serial line, idles high |
| parityEn | input | 1 | 1 = a parity bit follows the data |
| parityOdd | input | 1 | 0 = even parity, 1 = odd parity |
| clrFull | input | 1 | Write-1 clear of full |
| clrOverrun | input | 1 | Write-1 clear of overrun |
| clrParity | input | 1 | Write-1 clear of parityErr |
| clrFrame | input | 1 | Write-1 clear of frameErr |
| rxData | output | DATA_BITS | Receive buffer |
| busy | output | 1 | Frame in progress |
| full | output | 1 | Buffer holds an unread byte |
| overrun | output | 1 | A byte was lost by overwrite |
| parityErr | output | 1 | Parity mismatch seen |
| frameErr | output | 1 | Low stop bit seen |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an overrun whose second byte differs from the first. The bench sends one frame, leaves full uncleared, then sends a second frame with a different value. It then checks that overrun rose, that the buffer shows the second byte, and that full was not cleared by anything other than a write of 1.

Start-bit rejection is driven with a short low pulse that ends well before the midpoint. The bench then sends a clean frame to show that the receiver recovered.

The data path is swept across all 256 byte values with parity off and again with even parity. A wrong parity bit is injected under odd parity, and a low stop bit is injected to trigger a framing error.

// File: rtl/msb_rx_pkg.sv
package msb_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  // Strobes issued by the control to the datapath, one cycle wide.
  typedef struct packed {
    logic shiftEn;   // sample a data bit into the shift register
    logic parSample; // sample the parity bit
    logic load;      // sample the stop bit and commit the byte
  } rxStrobe_t;

endpackage

// File: rtl/msb_rx_ctrl.sv
module msb_rx_ctrl
  import msb_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_BITS     = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      rxBit,
  input  logic      parityEn,
  output rxStrobe_t stb,
  output logic      busy
);

  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(TICKS_PER_BIT / 2 - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_BITS - 1);

  rxState_t         state, stateNxt;
  logic [CNT_W-1:0] tickCnt, tickCntNxt;
  logic [BIT_W-1:0] bitCnt, bitCntNxt;
  logic             bitEnd;

  assign bitEnd = tickEn && (tickCnt == LAST_TICK);

  always_comb begin
    stateNxt   = state;
    tickCntNxt = tickCnt;
    bitCntNxt  = bitCnt;
    unique case (state)
      ST_IDLE: begin
        if (tickEn && !rxBit) begin
          stateNxt   = ST_START;
          tickCntNxt = '0;
        end
      end
      ST_START: begin
        if (tickEn) begin
          if (tickCnt == MID_TICK) begin
            tickCntNxt = '0;
            bitCntNxt  = '0;
            stateNxt   = rxBit ? ST_IDLE : ST_DATA;
          end else begin
            tickCntNxt = tickCnt + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tickEn) begin
          if (tickCnt == LAST_TICK) begin
            tickCntNxt = '0;
            if (bitCnt == LAST_BIT) begin
              stateNxt = parityEn ? ST_PAR : ST_STOP;
            end else begin
              bitCntNxt = bitCnt + 1'b1;
            end
          end else begin
            tickCntNxt = tickCnt + 1'b1;
          end
        end
      end
      ST_PAR, ST_STOP: begin
        if (tickEn) begin
          if (tickCnt == LAST_TICK) begin
            tickCntNxt = '0;
            stateNxt   = (state == ST_PAR) ? ST_STOP : ST_IDLE;
          end else begin
            tickCntNxt = tickCnt + 1'b1;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= stateNxt;
      tickCnt <= tickCntNxt;
      bitCnt  <= bitCntNxt;
    end
  end

  always_comb begin
    stb.shiftEn   = (state == ST_DATA) && bitEnd;
    stb.parSample = (state == ST_PAR)  && bitEnd;
    stb.load      = (state == ST_STOP) && bitEnd;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/msb_rx_dpath.sv
module msb_rx_dpath
  import msb_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serialIn,
  input  rxStrobe_t            stb,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 clrFull,
  input  logic                 clrOverrun,
  input  logic                 clrParity,
  input  logic                 clrFrame,
  output logic                 rxBit,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 full,
  output logic                 overrun,
  output logic                 parityErr,
  output logic                 frameErr
);

  logic [SYNC_DEPTH-1:0] syncReg;
  logic [DATA_BITS-1:0]  shiftReg;
  logic                  parBit;
  logic                  parBad;

  // Metastability guard on the asynchronous line; resets to the idle level.
  generate
    if (SYNC_DEPTH == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= serialIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= {syncReg[SYNC_DEPTH-2:0], serialIn};
      end
    end
  endgenerate

  assign rxBit = syncReg[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (stb.shiftEn)   shiftReg <= {shiftReg[DATA_BITS-2:0], rxBit};
      if (stb.parSample) parBit   <= rxBit;
    end
  end

  assign parBad = parityEn && (parBit != ((^shiftReg) ^ parityOdd));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      full      <= 1'b0;
      overrun   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      if (stb.load) rxData <= shiftReg;
      full      <= stb.load | (full & ~clrFull);
      overrun   <= (stb.load & full) | (overrun & ~clrOverrun);
      parityErr <= (stb.load & parBad) | (parityErr & ~clrParity);
      frameErr  <= (stb.load & ~rxBit) | (frameErr & ~clrFrame);
    end
  end

endmodule

// File: rtl/msb_uart_rx.sv
module msb_uart_rx
  import msb_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_BITS     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 serialIn,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 clrFull,
  input  logic                 clrOverrun,
  input  logic                 clrParity,
  input  logic                 clrFrame,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 busy,
  output logic                 full,
  output logic                 overrun,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic                 irq
);

  rxStrobe_t stb;
  logic      rxBit;

  msb_rx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .DATA_BITS    (DATA_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .rxBit   (rxBit),
    .parityEn(parityEn),
    .stb     (stb),
    .busy    (busy)
  );

  msb_rx_dpath #(
    .DATA_BITS (DATA_BITS),
    .SYNC_DEPTH(2)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .stb       (stb),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .clrFull   (clrFull),
    .clrOverrun(clrOverrun),
    .clrParity (clrParity),
    .clrFrame  (clrFrame),
    .rxBit     (rxBit),
    .rxData    (rxData),
    .full      (full),
    .overrun   (overrun),
    .parityErr (parityErr),
    .frameErr  (frameErr)
  );

  assign irq = full | overrun;

endmodule

// File: rtl/msb_uart_rx_chk.sv
module msb_uart_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 parityEn,
  input logic                 clrFull,
  input logic                 clrOverrun,
  input logic                 clrParity,
  input logic                 clrFrame,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 busy,
  input logic                 full,
  input logic                 overrun,
  input logic                 parityErr,
  input logic                 frameErr
);

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(full) |-> $past(clrFull)); // R6

  AST_LOAD_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(full) |-> !busy); // R8

  AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(full)); // R7

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrun) |-> $past(clrOverrun)); // R7

  AST_BUFFER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(rxData)); // R4

  AST_PARITY_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> $past(parityEn)); // R5

  AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameErr) |-> $past(clrFrame)); // R9

  AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(parityErr) |-> $past(clrParity)); // R5

endmodule

bind msb_uart_rx msb_uart_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .parityEn  (parityEn),
  .clrFull   (clrFull),
  .clrOverrun(clrOverrun),
  .clrParity (clrParity),
  .clrFrame  (clrFrame),
  .rxData    (rxData),
  .busy      (busy),
  .full      (full),
  .overrun   (overrun),
  .parityErr (parityErr),
  .frameErr  (frameErr)
);

// File: tb/test_msb_uart_rx.sv
module test_msb_uart_rx;

  localparam int TPB = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       serialIn = 1'b1;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       clrFull = 1'b0;
  logic       clrOverrun = 1'b0;
  logic       clrParity = 1'b0;
  logic       clrFrame = 1'b0;
  logic [7:0] rxData;
  logic       busy, full, overrun, parityErr, frameErr, irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  msb_uart_rx #(.TICKS_PER_BIT(TPB), .DATA_BITS(8)) i_msb_uart_rx (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .serialIn(serialIn),
    .parityEn(parityEn), .parityOdd(parityOdd),
    .clrFull(clrFull), .clrOverrun(clrOverrun),
    .clrParity(clrParity), .clrFrame(clrFrame),
    .rxData(rxData), .busy(busy), .full(full), .overrun(overrun),
    .parityErr(parityErr), .frameErr(frameErr), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic holdBit(input logic b);
    serialIn = b;
    repeat (TPB) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit usePar,
                           input logic parBit, input logic stopBit);
    @(negedge clk);
    holdBit(1'b0);
    chk("R8 busy during frame", busy, 1);
    for (int i = 7; i >= 0; i--) holdBit(d[i]);
    if (usePar) holdBit(parBit);
    holdBit(stopBit);
    serialIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 rxData", rxData, 0);
    chk("R11 busy", busy, 0);
    chk("R11 full", full, 0);
    chk("R11 overrun", overrun, 0);
    chk("R11 parityErr", parityErr, 0);
    chk("R11 frameErr", frameErr, 0);
    chk("R11 irq", irq, 0);
    rstN = 1'b1;

    // R1: idle line high
    repeat (100) @(negedge clk);
    chk("R1 idle busy", busy, 0);
    chk("R1 idle full", full, 0);

    // R2: short glitch rejected
    serialIn = 1'b0;
    repeat (4) @(negedge clk);
    serialIn = 1'b1;
    repeat (3 * TPB) @(negedge clk);
    chk("R2 glitch busy", busy, 0);
    chk("R2 glitch full", full, 0);
    chk("R2 glitch frameErr", frameErr, 0);

    // R3 R4 R6 R10: full byte sweep, no parity
    for (int v = 0; v < 256; v++) begin
      sendFrame(8'(v), 1'b0, 1'b0, 1'b1);
      chk("R3 data", rxData, v);
      chk("R6 full set", full, 1);
      chk("R8 idle after load", busy, 0);
      chk("R10 irq on full", irq, 1);
      chk("R5 no parity err when off", parityErr, 0);
      pulse(clrFull);
      @(negedge clk);
      chk("R6 full cleared", full, 0);
      chk("R10 irq clear", irq, 0);
      chk("R4 data held", rxData, v);
    end

    // R5: even parity sweep, correct parity bit
    parityEn = 1'b1;
    parityOdd = 1'b0;
    for (int v = 0; v < 256; v++) begin
      sendFrame(8'(v), 1'b1, ^8'(v), 1'b1);
      chk("R5 even data", rxData, v);
      chk("R5 even no err", parityErr, 0);
      pulse(clrFull);
    end

    // R5: odd parity, wrong then right
    parityOdd = 1'b1;
    sendFrame(8'hA5, 1'b1, ^8'hA5, 1'b1);
    chk("R5 odd wrong sets err", parityErr, 1);
    chk("R5 odd data still loaded", rxData, 8'hA5);
    pulse(clrParity);
    pulse(clrFull);
    @(negedge clk);
    chk("R5 err cleared", parityErr, 0);
    sendFrame(8'h3C, 1'b1, ~(^8'h3C), 1'b1);
    chk("R5 odd right no err", parityErr, 0);
    pulse(clrFull);
    parityEn = 1'b0;
    parityOdd = 1'b0;

    // R7: overrun with overwrite
    sendFrame(8'h11, 1'b0, 1'b0, 1'b1);
    repeat (50) @(negedge clk);
    chk("R6 full holds without clear", full, 1);
    chk("R7 no overrun yet", overrun, 0);
    sendFrame(8'hEE, 1'b0, 1'b0, 1'b1);
    chk("R7 overrun set", overrun, 1);
    chk("R7 new byte wins", rxData, 8'hEE);
    pulse(clrFull);
    @(negedge clk);
    chk("R10 irq held by overrun", irq, 1);
    chk("R7 overrun sticky", overrun, 1);
    pulse(clrOverrun);
    @(negedge clk);
    chk("R7 overrun cleared", overrun, 0);
    chk("R10 irq low", irq, 0);

    // R9: framing error
    sendFrame(8'h5A, 1'b0, 1'b0, 1'b0);
    chk("R9 frameErr set", frameErr, 1);
    chk("R9 byte loaded", rxData, 8'h5A);
    repeat (2 * TPB) @(negedge clk);
    chk("R9 frameErr sticky", frameErr, 1);
    pulse(clrFrame);
    pulse(clrFull);
    @(negedge clk);
    chk("R9 frameErr cleared", frameErr, 0);

    // R2: recovery after glitch
    serialIn = 1'b0;
    repeat (3) @(negedge clk);
    serialIn = 1'b1;
    repeat (2 * TPB) @(negedge clk);
    sendFrame(8'h81, 1'b0, 1'b0, 1'b1);
    chk("R2 frame after glitch", rxData, 8'h81);
    chk("R2 full after glitch", full, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule